// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged L1 Load Lookup

This block is the read side of a small first-level data cache. A load presents a virtual address. The set index and the byte position come only from the untranslated page-offset bits. This lets the tag and data arrays for that set be read in the same cycle that a small fully associative TLB translates the virtual page number. In the next cycle, the translated physical page number is compared against the tag of every way, and the matching way's word is steered to the output. The unit reports one of three outcomes: a hit with data, a cache miss, or a translation miss.

Line refill and TLB refill each use a plain write port. A refill always lands in the way named by a per-set round-robin pointer, so the refill source never has to choose a victim. The default geometry is a 32 KiB array: 64 sets of 8 ways, 64-byte lines and 4 KiB pages. Larger capacities must add ways, not sets.

Top module: `vipt_l1_lookup`

## Requirements
- R1: The byte-in-line field is VA[5:0], with the 64-bit word chosen by VA[5:3]. The set field is VA[11:6]. Elaboration stops if log2(SETS)+log2(LINE_BYTES) exceeds the page-offset width.
- R2: A request sampled with req_valid high yields resp_valid high exactly two cycles later, and back-to-back requests are accepted every cycle. Without a request, resp_valid stays low.
- R3: A hit occurs when a valid TLB entry maps VA[31:12] to a physical page equal to the stored tag of a valid way in set VA[11:6]. On a hit, resp_hit is high and resp_data is word VA[5:3] of that line, where word w is line bits [64w+63:64w].
- R4: When the translation is valid but no valid way of the set holds the physical page, resp_miss is high and resp_data is zero.
- R5: When no valid TLB entry matches VA[31:12], resp_tlb_miss is high and both resp_hit and resp_miss are low, even if a way holds a matching tag.
- R6: With resp_valid high, exactly one of resp_hit, resp_miss and resp_tlb_miss is high. With resp_valid low, all three are low.
- R7: Reset clears every cache way valid bit, every TLB entry valid bit and every round-robin pointer, and drives all response outputs low.
- R8: A refill writes the line, the tag and the valid bit into set refill_set, at the way given by that set's pointer. The pointer starts at way 0 and advances by one, modulo 8, on each refill to that set. Other sets are untouched, and writing valid 0 removes the line.
- R9: A TLB write sets the VPN, PPN and valid bit of entry tlb_wr_idx, replacing its old contents. Two virtual pages mapped to one physical page hit the same line.
- R10: At most one way matches per lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Load lookup request |
| req_va | input | 32 | Virtual address of the load |
| resp_valid | output | 1 | Response for the request two cycles earlier |
| resp_hit | output | 1 | Cache hit |
| resp_miss | output | 1 | Cache miss with valid translation |
| resp_tlb_miss | output | 1 | No translation for the page |
| resp_data | output | 64 | Selected word on a hit, zero otherwise |
| refill_en | input | 1 | Line refill strobe |
| refill_set | input | 6 | Set to refill |
| refill_tag | input | 20 | Physical page stored as tag |
| refill_valid | input | 1 | Valid bit written with the line |
| refill_line | input | 512 | Line contents |
| tlb_wr_en | input | 1 | TLB write strobe |
| tlb_wr_idx | input | 3 | TLB entry to write |
| tlb_wr_valid | input | 1 | Valid bit of the entry |
| tlb_wr_vpn | input | 20 | Virtual page number |
| tlb_wr_ppn | input | 20 | Physical page number |

## Verification
On every cycle, the assertions check the following: the two-cycle response timing, the exclusivity of the three outcomes, the rule that a translation miss beats the cache result, zero data on anything but a hit, and the one-hot way match. Whether the right word of the right line comes back depends on the history of refills and TLB writes. The bench's scenarios alone show this, including the round-robin victim order and eviction on the ninth refill of a set, invalidation by a zero-valid refill, aliased virtual pages, and the clearing of all state by a reset in mid-run.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
   typedef enum logic [1:0] {
      KIND_NONE    = 2'd0,
      KIND_HIT     = 2'd1,
      KIND_MISS    = 2'd2,
      KIND_TLBMISS = 2'd3
   } resp_kind_e;
endpackage

// File: rtl/vipt_tlb.sv
module vipt_tlb #(
   parameter int ENTRIES = 8,
   parameter int VPN_W   = 20,
   parameter int PPN_W   = 20
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic [VPN_W-1:0]           lk_vpn,
   input  logic                       wr_en,
   input  logic [$clog2(ENTRIES)-1:0] wr_idx,
   input  logic                       wr_valid,
   input  logic [VPN_W-1:0]           wr_vpn,
   input  logic [PPN_W-1:0]           wr_ppn,
   output logic                       hit,
   output logic [PPN_W-1:0]           ppn
);
   generate
      if (ENTRIES < 2 || (ENTRIES & (ENTRIES - 1)) != 0) begin : g_bad_entries
         $error("TLB entry count must be a power of two of at least 2");
      end
   endgenerate

   logic [ENTRIES-1:0] v_q;
   logic [VPN_W-1:0]   vpn_q [ENTRIES];
   logic [PPN_W-1:0]   ppn_q [ENTRIES];
   logic               m_hit;
   logic [PPN_W-1:0]   m_ppn;

   // CAM match; the lowest matching index wins
   always_comb begin
      m_hit = 1'b0;
      m_ppn = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (v_q[i] && vpn_q[i] == lk_vpn) begin
            m_hit = 1'b1;
            m_ppn = ppn_q[i];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         v_q <= '0;
         hit <= 1'b0;
         ppn <= '0;
      end else begin
         if (wr_en) begin
            v_q[wr_idx]   <= wr_valid;
            vpn_q[wr_idx] <= wr_vpn;
            ppn_q[wr_idx] <= wr_ppn;
         end
         hit <= m_hit;
         ppn <= m_ppn;
      end
   end
endmodule

// File: rtl/vipt_tag_array.sv
module vipt_tag_array #(
   parameter int SETS  = 64,
   parameter int WAYS  = 8,
   parameter int TAG_W = 20
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic [$clog2(SETS)-1:0]   rd_idx,
   output logic [WAYS*TAG_W-1:0]     rd_tags,
   output logic [WAYS-1:0]           rd_vld,
   input  logic                      wr_en,
   input  logic [$clog2(SETS)-1:0]   wr_idx,
   input  logic [TAG_W-1:0]          wr_tag,
   input  logic                      wr_vld,
   output logic [$clog2(WAYS)-1:0]   wr_way
);
   localparam int WAY_W = $clog2(WAYS);

   logic [TAG_W-1:0] tag_q [SETS][WAYS];
   logic [WAYS-1:0]  vld_q [SETS];
   logic [WAY_W-1:0] rr_q  [SETS];

   assign wr_way = rr_q[wr_idx];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int s = 0; s < SETS; s++) begin
            vld_q[s] <= '0;
            rr_q[s]  <= '0;
         end
         rd_vld <= '0;
      end else begin
         if (wr_en) begin
            tag_q[wr_idx][wr_way] <= wr_tag;
            vld_q[wr_idx][wr_way] <= wr_vld;
            rr_q[wr_idx]          <= wr_way + 1'b1;
         end
         rd_vld <= vld_q[rd_idx];
      end
   end

   // all ways of the indexed set are read together
   always_ff @(posedge clk) begin
      for (int w = 0; w < WAYS; w++) begin
         rd_tags[w*TAG_W +: TAG_W] <= tag_q[rd_idx][w];
      end
   end
endmodule

// File: rtl/vipt_data_array.sv
module vipt_data_array #(
   parameter int SETS   = 64,
   parameter int WAYS   = 8,
   parameter int LINE_W = 512,
   parameter int WORD_W = 64
) (
   input  logic                                clk,
   input  logic [$clog2(SETS)-1:0]             rd_idx,
   input  logic [$clog2(LINE_W/WORD_W)-1:0]    rd_word,
   output logic [WAYS*WORD_W-1:0]              rd_words,
   input  logic                                wr_en,
   input  logic [$clog2(SETS)-1:0]             wr_idx,
   input  logic [$clog2(WAYS)-1:0]             wr_way,
   input  logic [LINE_W-1:0]                   wr_line
);
   logic [LINE_W-1:0] mem_q [SETS][WAYS];

   always_ff @(posedge clk) begin
      if (wr_en) begin
         mem_q[wr_idx][wr_way] <= wr_line;
      end
      for (int w = 0; w < WAYS; w++) begin
         rd_words[w*WORD_W +: WORD_W] <= mem_q[rd_idx][w][rd_word*WORD_W +: WORD_W];
      end
   end
endmodule

// File: rtl/vipt_l1_lookup.sv
module vipt_l1_lookup
   import vipt_pkg::*;
#(
   parameter int VA_W        = 32,
   parameter int PA_W        = 32,
   parameter int PAGE_OFF_W  = 12,
   parameter int LINE_BYTES  = 64,
   parameter int SETS        = 64,
   parameter int WAYS        = 8,
   parameter int WORD_W      = 64,
   parameter int TLB_ENTRIES = 8
) (
   input  logic                               clk,
   input  logic                               rst,
   input  logic                               req_valid,
   input  logic [VA_W-1:0]                    req_va,
   output logic                               resp_valid,
   output logic                               resp_hit,
   output logic                               resp_miss,
   output logic                               resp_tlb_miss,
   output logic [WORD_W-1:0]                  resp_data,
   input  logic                               refill_en,
   input  logic [$clog2(SETS)-1:0]            refill_set,
   input  logic [PA_W-PAGE_OFF_W-1:0]         refill_tag,
   input  logic                               refill_valid,
   input  logic [LINE_BYTES*8-1:0]            refill_line,
   input  logic                               tlb_wr_en,
   input  logic [$clog2(TLB_ENTRIES)-1:0]     tlb_wr_idx,
   input  logic                               tlb_wr_valid,
   input  logic [VA_W-PAGE_OFF_W-1:0]         tlb_wr_vpn,
   input  logic [PA_W-PAGE_OFF_W-1:0]         tlb_wr_ppn
);
   localparam int OFF_W  = $clog2(LINE_BYTES);
   localparam int IDX_W  = $clog2(SETS);
   localparam int LINE_W = LINE_BYTES * 8;
   localparam int BYTE_W = $clog2(WORD_W / 8);
   localparam int VPN_W  = VA_W - PAGE_OFF_W;
   localparam int PPN_W  = PA_W - PAGE_OFF_W;
   localparam int WAY_W  = $clog2(WAYS);

   // R1: index and line offset must stay inside the untranslated page offset
   generate
      if (IDX_W + OFF_W > PAGE_OFF_W) begin : g_bad_geometry
         $error("sets x line size exceeds page size: raise associativity instead");
      end
      if ((WAYS & (WAYS - 1)) != 0 || WAYS < 2) begin : g_bad_ways
         $error("way count must be a power of two of at least 2");
      end
      if (LINE_W % WORD_W != 0 || LINE_W == WORD_W) begin : g_bad_word
         $error("line must hold several whole words");
      end
   endgenerate

   logic                    s1_valid;
   logic                    s1_tlb_hit;
   logic [PPN_W-1:0]        s1_ppn;
   logic [WAYS*PPN_W-1:0]   s1_tags;
   logic [WAYS-1:0]         s1_vld;
   logic [WAYS*WORD_W-1:0]  s1_words;
   logic [WAY_W-1:0]        fill_way;
   logic [WAYS-1:0]         way_hit;
   logic [WORD_W-1:0]       sel_word;
   resp_kind_e              kind;

   always_ff @(posedge clk) begin
      if (rst) s1_valid <= 1'b0;
      else     s1_valid <= req_valid;
   end

   // stage 1: translation and array read run side by side
   vipt_tlb #(.ENTRIES(TLB_ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_tlb (
      .clk(clk), .rst(rst),
      .lk_vpn(req_va[VA_W-1:PAGE_OFF_W]),
      .wr_en(tlb_wr_en), .wr_idx(tlb_wr_idx), .wr_valid(tlb_wr_valid),
      .wr_vpn(tlb_wr_vpn), .wr_ppn(tlb_wr_ppn),
      .hit(s1_tlb_hit), .ppn(s1_ppn)
   );

   vipt_tag_array #(.SETS(SETS), .WAYS(WAYS), .TAG_W(PPN_W)) u_tags (
      .clk(clk), .rst(rst),
      .rd_idx(req_va[OFF_W+IDX_W-1:OFF_W]),
      .rd_tags(s1_tags), .rd_vld(s1_vld),
      .wr_en(refill_en), .wr_idx(refill_set), .wr_tag(refill_tag),
      .wr_vld(refill_valid), .wr_way(fill_way)
   );

   vipt_data_array #(.SETS(SETS), .WAYS(WAYS), .LINE_W(LINE_W), .WORD_W(WORD_W)) u_data (
      .clk(clk),
      .rd_idx(req_va[OFF_W+IDX_W-1:OFF_W]),
      .rd_word(req_va[OFF_W-1:BYTE_W]),
      .rd_words(s1_words),
      .wr_en(refill_en), .wr_idx(refill_set), .wr_way(fill_way),
      .wr_line(refill_line)
   );

   // stage 2: physical tag compare per way
   generate
      for (genvar w = 0; w < WAYS; w++) begin : g_cmp
         assign way_hit[w] = s1_valid & s1_tlb_hit & s1_vld[w] &
                             (s1_tags[w*PPN_W +: PPN_W] == s1_ppn);
      end
   endgenerate

   // one-hot way select
   always_comb begin
      sel_word = '0;
      for (int w = 0; w < WAYS; w++) begin
         sel_word = sel_word | (s1_words[w*WORD_W +: WORD_W] & {WORD_W{way_hit[w]}});
      end
   end

   always_comb begin
      if (!s1_valid)        kind = KIND_NONE;
      else if (!s1_tlb_hit) kind = KIND_TLBMISS;
      else if (|way_hit)    kind = KIND_HIT;
      else                  kind = KIND_MISS;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         resp_valid    <= 1'b0;
         resp_hit      <= 1'b0;
         resp_miss     <= 1'b0;
         resp_tlb_miss <= 1'b0;
         resp_data     <= '0;
      end else begin
         resp_valid    <= (kind != KIND_NONE);
         resp_hit      <= (kind == KIND_HIT);
         resp_miss     <= (kind == KIND_MISS);
         resp_tlb_miss <= (kind == KIND_TLBMISS);
         resp_data     <= (kind == KIND_HIT) ? sel_word : '0;
      end
   end
endmodule

// File: rtl/vipt_l1_chk.sv
module vipt_l1_chk #(
   parameter int WAYS   = 8,
   parameter int WORD_W = 64
) (
   input logic              clk,
   input logic              rst,
   input logic              req_valid,
   input logic              resp_valid,
   input logic              resp_hit,
   input logic              resp_miss,
   input logic              resp_tlb_miss,
   input logic [WORD_W-1:0] resp_data,
   input logic [WAYS-1:0]   way_hit
);
   assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
      req_valid |-> ##2 resp_valid);

   assert_no_spurious_R2: assert property (@(posedge clk) disable iff (rst)
      !req_valid |-> ##2 !resp_valid);

   assert_one_outcome_R6: assert property (@(posedge clk) disable iff (rst)
      resp_valid |-> $countones({resp_hit, resp_miss, resp_tlb_miss}) == 1);

   assert_quiet_idle_R6: assert property (@(posedge clk) disable iff (rst)
      !resp_valid |-> !(resp_hit || resp_miss || resp_tlb_miss));

   assert_tlb_first_R5: assert property (@(posedge clk) disable iff (rst)
      resp_tlb_miss |-> !resp_hit && !resp_miss);

   assert_zero_data_R4: assert property (@(posedge clk) disable iff (rst)
      !resp_hit |-> resp_data == '0);

   assert_way_onehot_R10: assert property (@(posedge clk) disable iff (rst)
      $onehot0(way_hit));
endmodule

bind vipt_l1_lookup vipt_l1_chk #(.WAYS(WAYS), .WORD_W(WORD_W)) u_chk (
   .clk(clk), .rst(rst), .req_valid(req_valid), .resp_valid(resp_valid),
   .resp_hit(resp_hit), .resp_miss(resp_miss), .resp_tlb_miss(resp_tlb_miss),
   .resp_data(resp_data), .way_hit(way_hit)
);

// File: tb/sim_vipt_l1_lookup.sv
module sim_vipt_l1_lookup;
   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         req_valid = 1'b0;
   logic [31:0]  req_va = '0;
   logic         resp_valid, resp_hit, resp_miss, resp_tlb_miss;
   logic [63:0]  resp_data;
   logic         refill_en = 1'b0;
   logic [5:0]   refill_set = '0;
   logic [19:0]  refill_tag = '0;
   logic         refill_valid = 1'b0;
   logic [511:0] refill_line = '0;
   logic         tlb_wr_en = 1'b0;
   logic [2:0]   tlb_wr_idx = '0;
   logic         tlb_wr_valid = 1'b0;
   logic [19:0]  tlb_wr_vpn = '0;
   logic [19:0]  tlb_wr_ppn = '0;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   vipt_l1_lookup u0 (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_va(req_va),
      .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_miss(resp_miss),
      .resp_tlb_miss(resp_tlb_miss), .resp_data(resp_data),
      .refill_en(refill_en), .refill_set(refill_set), .refill_tag(refill_tag),
      .refill_valid(refill_valid), .refill_line(refill_line),
      .tlb_wr_en(tlb_wr_en), .tlb_wr_idx(tlb_wr_idx), .tlb_wr_valid(tlb_wr_valid),
      .tlb_wr_vpn(tlb_wr_vpn), .tlb_wr_ppn(tlb_wr_ppn)
   );

   // reference state
   logic [19:0] m_tag [64][8];
   logic        m_v   [64][8];
   int          m_ptr [64];
   logic [19:0] t_vpn [8];
   logic [19:0] t_ppn [8];
   logic        t_v   [8];

   function automatic logic [63:0] pmem(input logic [31:0] pa);
      logic [31:0] a;
      a = {pa[31:3], 3'b000};
      return {a ^ 32'h5A5A_0F0F, a * 32'h9E37_79B1 + 32'd13};
   endfunction

   function automatic logic [511:0] line_of(input logic [19:0] ppn, input logic [5:0] set);
      logic [511:0] l;
      for (int w = 0; w < 8; w++) l[w*64 +: 64] = pmem({ppn, set, w[2:0], 3'b000});
      return l;
   endfunction

   // kind: 0 none, 1 hit, 2 miss, 3 tlb miss
   task automatic predict(input logic [31:0] va, output int kind, output logic [63:0] data);
      int te;
      logic [19:0] ppn;
      te = -1;
      for (int i = 7; i >= 0; i--) if (t_v[i] && t_vpn[i] == va[31:12]) te = i;
      data = '0;
      if (te < 0) kind = 3;
      else begin
         ppn = t_ppn[te];
         kind = 2;
         for (int w = 0; w < 8; w++)
            if (m_v[va[11:6]][w] && m_tag[va[11:6]][w] == ppn) begin
               kind = 1;
               data = pmem({ppn, va[11:3], 3'b000});
            end
      end
   endtask

   function automatic bit present(input logic [5:0] set, input logic [19:0] ppn);
      for (int w = 0; w < 8; w++) if (m_v[set][w] && m_tag[set][w] == ppn) return 1'b1;
      return 1'b0;
   endfunction

   task automatic model_clear();
      for (int s = 0; s < 64; s++) begin
         m_ptr[s] = 0;
         for (int w = 0; w < 8; w++) begin m_v[s][w] = 1'b0; m_tag[s][w] = '0; end
      end
      for (int i = 0; i < 8; i++) begin t_v[i] = 1'b0; t_vpn[i] = '0; t_ppn[i] = '0; end
   endtask

   // response monitor: expectation recorded two falling edges before its check
   logic        ev0 = 1'b0, ev1 = 1'b0;
   int          ek0 = 0, ek1 = 0;
   logic [63:0] ed0 = '0, ed1 = '0;
   logic [31:0] ea0 = '0, ea1 = '0;

   always @(negedge clk) begin
      if (rst) begin
         ev0 = 1'b0; ev1 = 1'b0; ek0 = 0; ek1 = 0; ed0 = '0; ed1 = '0;
      end else begin
         begin : chk
            string rq;
            logic [3:0] exp_f;
            logic [3:0] act_f;
            rq = (ek1 == 1) ? "R3" : (ek1 == 2) ? "R4" : (ek1 == 3) ? "R5" : "R2";
            exp_f = {ev1, ek1 == 1, ek1 == 2, ek1 == 3};
            act_f = {resp_valid, resp_hit, resp_miss, resp_tlb_miss};
            checks++;
            if (act_f !== exp_f || resp_data !== ed1) begin
               errors++;
               $display("FAIL %s/R6 va=%h flags act=%b exp=%b data act=%h exp=%h",
                        rq, ea1, act_f, exp_f, resp_data, ed1);
            end
         end
         ev1 = ev0; ek1 = ek0; ed1 = ed0; ea1 = ea0;
         ev0 = req_valid; ea0 = req_va;
         if (req_valid) predict(req_va, ek0, ed0);
         else begin ek0 = 0; ed0 = '0; end
      end
   end

   task automatic cyc();
      @(posedge clk); #1;
      req_valid = 1'b0; refill_en = 1'b0; tlb_wr_en = 1'b0; rst = 1'b0;
   endtask

   task automatic rq(input logic [19:0] vpn, input logic [5:0] set, input logic [5:0] off);
      cyc();
      req_valid = 1'b1;
      req_va = {vpn, set, off};
   endtask

   task automatic tw(input int idx, input logic [19:0] vpn, input logic [19:0] ppn, input bit v);
      cyc();
      tlb_wr_en = 1'b1; tlb_wr_idx = idx[2:0]; tlb_wr_vpn = vpn;
      tlb_wr_ppn = ppn; tlb_wr_valid = v;
      t_vpn[idx] = vpn; t_ppn[idx] = ppn; t_v[idx] = v;
   endtask

   task automatic rf(input logic [5:0] set, input logic [19:0] ppn, input bit v);
      cyc();
      refill_en = 1'b1; refill_set = set; refill_tag = ppn;
      refill_valid = v; refill_line = line_of(ppn, set);
      m_tag[set][m_ptr[set]] = ppn;
      m_v[set][m_ptr[set]] = v;
      m_ptr[set] = (m_ptr[set] + 1) % 8;
   endtask

   task automatic do_reset();
      @(posedge clk); #1;
      req_valid = 1'b0; refill_en = 1'b0; tlb_wr_en = 1'b0; rst = 1'b1;
      model_clear();
      repeat (2) @(posedge clk);
      #1 rst = 1'b0;
      @(negedge clk);
      checks++;   // R7: outputs quiet after reset
      if ({resp_valid, resp_hit, resp_miss, resp_tlb_miss} !== 4'b0 || resp_data !== '0) begin
         errors++;
         $display("FAIL R7 outputs after reset act=%b/%h exp=0000/0",
                  {resp_valid, resp_hit, resp_miss, resp_tlb_miss}, resp_data);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   localparam logic [5:0] SET_POOL [4] = '{6'd0, 6'd1, 6'd33, 6'd63};

   initial begin
      logic [19:0] vpn_pool [16];
      void'($urandom(32'd4242));
      model_clear();
      for (int k = 0; k < 16; k++) vpn_pool[k] = 20'h10000 + k * 20'h111;
      do_reset();

      // R7: TLB and cache empty after reset
      rq(20'h00200, 6'd5, 6'd8);        // expects tlb miss (R5/R7)
      tw(0, 20'h00200, 20'h00100, 1'b1);
      rq(20'h00200, 6'd5, 6'd8);        // expects cache miss (R4/R7)

      // R8: nine refills into set 5; way 0 is reused by the ninth
      for (int i = 0; i < 9; i++) rf(6'd5, 20'h00100 + 20'(i), 1'b1);
      rq(20'h00200, 6'd5, 6'd8);        // 0x100 evicted -> miss
      tw(0, 20'h00200, 20'h00101, 1'b1);
      for (int o = 0; o < 64; o += 8) rq(20'h00200, 6'd5, o[5:0]);  // R1/R3 every word
      rq(20'h00200, 6'd6, 6'd0);        // R8 other set untouched -> miss
      tw(0, 20'h00200, 20'h00108, 1'b1);
      rq(20'h00200, 6'd5, 6'd63);       // R3 hit in way 0

      // R9: two virtual pages aliasing one physical page
      tw(1, 20'h00300, 20'h00101, 1'b1);
      tw(2, 20'h00301, 20'h00101, 1'b1);
      rq(20'h00300, 6'd5, 6'd16);
      rq(20'h00301, 6'd5, 6'd16);
      tw(2, 20'h00301, 20'h00555, 1'b1); // R9 overwrite -> miss
      rq(20'h00301, 6'd5, 6'd16);
      tw(2, 20'h00301, 20'h00101, 1'b0); // R5 invalidated entry -> tlb miss
      rq(20'h00301, 6'd5, 6'd16);

      // R8: zero-valid refill lands on way 1 (holding 0x101) and removes it
      rf(6'd5, 20'h00101, 1'b0);
      rq(20'h00300, 6'd5, 6'd16);

      // random mix
      for (int n = 0; n < 4000; n++) begin
         int op, k;
         logic [5:0] set;
         logic [19:0] ppn;
         op  = $urandom % 100;
         k   = $urandom % 16;
         set = SET_POOL[$urandom % 4];
         if (op < 8) begin
            tw(k % 8, vpn_pool[k], 20'h08000 | 20'($urandom % 24), ($urandom % 8) != 0);
         end else if (op < 22) begin
            if (t_v[k % 8] && t_vpn[k % 8] == vpn_pool[k] && ($urandom % 4) != 0)
               ppn = t_ppn[k % 8];
            else
               ppn = 20'h08000 | 20'($urandom % 24);
            if (present(set, ppn)) rq(vpn_pool[k], set, 6'($urandom));
            else rf(set, ppn, ($urandom % 10) != 0);
         end else if (op < 27) begin
            cyc();
         end else begin
            rq(vpn_pool[k], set, 6'($urandom));
         end
         if (n == 2500) begin
            cyc(); cyc(); cyc();
            do_reset();
            rq(vpn_pool[0], SET_POOL[0], 6'd0);    // R7: tlb cleared
            tw(0, vpn_pool[0], 20'h08000, 1'b1);
            for (int s = 0; s < 4; s++) rq(vpn_pool[0], SET_POOL[s], 6'd0); // R7: ways cleared
         end
      end

      cyc(); cyc(); cyc(); cyc();
      summary();
      $finish;
   end
endmodule